// File: doc/BRIEF.md
# Planar Pixel Serializer

The serializer takes a 32-bit snapshot made of four plane bytes and turns it into a stream of 4-bit pixel values, one value per pixel-clock enable. The caller chooses one of four shift formats. In the per-plane format each plane gives one bit to every pixel. In the paired format planes 0 and 1 act as one shifter and planes 2 and 3 act as another, and each pair gives two bits to every pixel. In the whole-word format four bits at a time come from the full 32-bit register. The chained single-bit format serves the 64K one-bit-per-pixel case: each plane pair is emptied one bit at a time over two character clocks.

A character strobe marks each character clock, and one character clock is eight pixel clocks. An internal load divider turns these strobes into load pulses. It can load on every strobe, on every second strobe or on every fourth strobe. A pulse loads the plane data into the shift register. Strobes that fall between load pulses leave the register untouched, so a snapshot can last for two or four character clocks.

Top module: `plane_serializer`

## Requirements
- R1: While reset is held, `pix` reads 0 and the divider returns to phase zero, so the first character strobe after reset always loads.
- R2: In format 0 (per-plane), pixel k of a load (k = 0..7) has bit p equal to bit 7-k of plane p. Plane p sits at `plane_data[8p+7:8p]`.
- R3: In format 1 (paired), build A = {plane0, plane1} and B = {plane2, plane3}. Pixel k has `pix[1:0]` = A[15-2k:14-2k] and `pix[3:2]` = B[15-2k:14-2k], for k = 0..7.
- R4: In format 2 (whole-word), build W = {plane0, plane1, plane2, plane3}. Pixel k is W[31-4k:28-4k], for k = 0..7.
- R5: In format 3 (chained single-bit), with A and B built as in R3, pixel k has `pix[0]` = A[15-k] and `pix[2]` = B[15-k], with bits 1 and 3 at 0, for k = 0..15.
- R6: A load and a pixel enable in the same cycle show pixel 0 of the new data on `pix` after that clock edge. Each further enable advances one pixel.
- R7: While `pix_en` is low, `pix` holds and the shifter does not advance. A load in such a cycle stores the data, and the next enable shows pixel 0 of that data.
- R8: `div_sel` 0 loads on every strobe, 1 on every second strobe and 2 or 3 on every fourth strobe, counting from the first strobe after reset. Strobes that do not load leave the register unchanged.
- R9: Once all loaded bits have been shifted out, further pixels read 0 until the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_stb | input | 1 | Character-clock strobe, fed to the load divider |
| pix_en | input | 1 | Pixel-clock enable; advances the serializer |
| mode | input | 2 | Shift format: 0 per-plane, 1 paired, 2 whole-word, 3 chained single-bit |
| div_sel | input | 2 | Load ratio: 0 every strobe, 1 every second, 2/3 every fourth |
| plane_data | input | 32 | Four plane bytes, plane p in bits 8p+7..8p |
| pix | output | 4 | Registered pixel value |

## Verification
The bench builds the block with its default parameters: 8-bit planes and a largest load ratio of 4. With these values all four formats and all three load ratios can be reached. One-per-strobe loading drives the eight-pixel formats. Ratio two with the chained format runs the full sixteen-pixel window. Ratio four makes the shifter run dry, which shows the zero fill, and it also shows that strobes between loads are ignored because the bench presents fresh data at those strobes.

// File: rtl/pser_pkg.sv
package pser_pkg;
   typedef enum logic [1:0] {
      PS_FMT_PLANE = 2'd0,
      PS_FMT_PAIR  = 2'd1,
      PS_FMT_WORD  = 2'd2,
      PS_FMT_CHAIN = 2'd3
   } ps_fmt_e;
endpackage

// File: rtl/pser_load_div.sv
module pser_load_div #(
   parameter int MAX_RATIO = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       char_stb,
   input  logic [1:0] div_sel,
   output logic       load
);
   localparam int CNT_W = (MAX_RATIO > 2) ? $clog2(MAX_RATIO) : 1;

   logic [CNT_W-1:0] phase;
   logic [CNT_W-1:0] limit;

   always_comb begin
      case (div_sel)
         2'd0:    limit = '0;
         2'd1:    limit = CNT_W'(1);
         default: limit = CNT_W'(MAX_RATIO - 1);
      endcase
   end

   assign load = char_stb && (phase == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         phase <= '0;
      else if (char_stb)
         phase <= (phase >= limit) ? '0 : phase + CNT_W'(1);
   end
endmodule

// File: rtl/pser_tap.sv
module pser_tap #(
   parameter int PLANE_W = 8
) (
   input  logic [4*PLANE_W-1:0] word,
   input  logic [1:0]           mode,
   output logic [3:0]           pix
);
   import pser_pkg::*;
   localparam int WW = 4 * PLANE_W;
   localparam int HW = 2 * PLANE_W;

   logic [3:0] plane_px;

   for (genvar p = 0; p < 4; p++) begin : g_plane_tap
      assign plane_px[p] = word[WW-1-p*PLANE_W];
   end

   always_comb begin
      case (ps_fmt_e'(mode))
         PS_FMT_PLANE: pix = plane_px;
         PS_FMT_PAIR:  pix = {word[HW-1 -: 2], word[WW-1 -: 2]};
         PS_FMT_WORD:  pix = word[WW-1 -: 4];
         default:      pix = {1'b0, word[HW-1], 1'b0, word[WW-1]};
      endcase
   end
endmodule

// File: rtl/pser_step.sv
module pser_step #(
   parameter int PLANE_W = 8
) (
   input  logic [4*PLANE_W-1:0] word,
   input  logic [1:0]           mode,
   output logic [4*PLANE_W-1:0] next
);
   import pser_pkg::*;
   localparam int WW = 4 * PLANE_W;
   localparam int HW = 2 * PLANE_W;

   logic [WW-1:0] by_plane;
   logic [WW-1:0] by_pair2;
   logic [WW-1:0] by_pair1;

   for (genvar p = 0; p < 4; p++) begin : g_plane_shift
      assign by_plane[p*PLANE_W +: PLANE_W] = {word[p*PLANE_W +: PLANE_W-1], 1'b0};
   end

   for (genvar h = 0; h < 2; h++) begin : g_pair_shift
      assign by_pair2[h*HW +: HW] = {word[h*HW +: HW-2], 2'b00};
      assign by_pair1[h*HW +: HW] = {word[h*HW +: HW-1], 1'b0};
   end

   always_comb begin
      case (ps_fmt_e'(mode))
         PS_FMT_PLANE: next = by_plane;
         PS_FMT_PAIR:  next = by_pair2;
         PS_FMT_WORD:  next = {word[WW-5:0], 4'b0000};
         default:      next = by_pair1;
      endcase
   end
endmodule

// File: rtl/plane_serializer.sv
module plane_serializer #(
   parameter int PLANE_W   = 8,
   parameter int MAX_RATIO = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 char_stb,
   input  logic                 pix_en,
   input  logic [1:0]           mode,
   input  logic [1:0]           div_sel,
   input  logic [4*PLANE_W-1:0] plane_data,
   output logic [3:0]           pix
);
   localparam int WW = 4 * PLANE_W;

   if (PLANE_W < 4 || (PLANE_W % 2) != 0) begin : g_bad_width
      $error("plane_serializer: PLANE_W must be even and at least 4");
   end
   if (MAX_RATIO < 2) begin : g_bad_ratio
      $error("plane_serializer: MAX_RATIO must be at least 2");
   end

   logic          ld_fire;
   logic [WW-1:0] shreg;
   logic [WW-1:0] load_word;
   logic [WW-1:0] src_word;
   logic [WW-1:0] step_word;
   logic [3:0]    tap_pix;

   for (genvar p = 0; p < 4; p++) begin : g_reorder
      assign load_word[WW-1-p*PLANE_W -: PLANE_W] = plane_data[p*PLANE_W +: PLANE_W];
   end

   pser_load_div #(.MAX_RATIO(MAX_RATIO)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .char_stb (char_stb),
      .div_sel  (div_sel),
      .load     (ld_fire)
   );

   assign src_word = ld_fire ? load_word : shreg;

   pser_tap #(.PLANE_W(PLANE_W)) u_tap (
      .word (src_word),
      .mode (mode),
      .pix  (tap_pix)
   );

   pser_step #(.PLANE_W(PLANE_W)) u_step (
      .word (src_word),
      .mode (mode),
      .next (step_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= '0;
         pix   <= '0;
      end else if (pix_en) begin
         shreg <= step_word;
         pix   <= tap_pix;
      end else if (ld_fire) begin
         shreg <= load_word;
      end
   end
endmodule

// File: rtl/plane_serializer_chk.sv
module plane_serializer_chk #(
   parameter int PLANE_W = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 char_stb,
   input logic                 pix_en,
   input logic [1:0]           div_sel,
   input logic [4*PLANE_W-1:0] plane_data,
   input logic                 ld_fire,
   input logic [3:0]           pix
);
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_en |=> $stable(pix)); // R7

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pix == 4'd0)); // R1

   AST_LOAD_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
      ld_fire |-> char_stb); // R8

   AST_RATIO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (char_stb && div_sel == 2'd0) |-> ld_fire); // R8

   AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_fire && div_sel != 2'd0) |=> !ld_fire); // R8

   AST_ZERO_LOAD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_fire && pix_en && plane_data == '0) |=> (pix == 4'd0)); // R6
endmodule

bind plane_serializer plane_serializer_chk #(.PLANE_W(PLANE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .char_stb   (char_stb),
   .pix_en     (pix_en),
   .div_sel    (div_sel),
   .plane_data (plane_data),
   .ld_fire    (ld_fire),
   .pix        (pix)
);

// File: tb/plane_serializer_bench.sv
`timescale 1ns/1ps
module plane_serializer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        char_stb = 1'b0;
   logic        pix_en = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic [1:0]  div_sel = 2'd0;
   logic [31:0] plane_data = 32'd0;
   logic [3:0]  pix;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   plane_serializer u_plane_serializer (
      .clk (clk), .rst_n (rst_n), .char_stb (char_stb), .pix_en (pix_en),
      .mode (mode), .div_sel (div_sel), .plane_data (plane_data), .pix (pix)
   );

   function automatic logic [3:0] exp_pix(input logic [31:0] d, input int m, input int k);
      logic [7:0]  pl [4];
      logic [15:0] a, b;
      logic [31:0] w;
      logic [3:0]  r;
      for (int p = 0; p < 4; p++) pl[p] = d[8*p +: 8];
      a = {pl[0], pl[1]};
      b = {pl[2], pl[3]};
      w = {pl[0], pl[1], pl[2], pl[3]};
      r = 4'd0;
      case (m)
         0: if (k < 8) for (int p = 0; p < 4; p++) r[p] = pl[p][7-k];
         1: if (k < 8) r = {b[15-2*k -: 2], a[15-2*k -: 2]};
         2: if (k < 8) r = w[31-4*k -: 4];
         default: if (k < 16) r = {1'b0, b[15-k], 1'b0, a[15-k]};
      endcase
      return r;
   endfunction

   task automatic check(input logic [3:0] exp, input string tag);
      n_cmp++;
      if (pix !== exp) begin
         n_bad++;
         $display("FAIL %s: pix=%h expected=%h", tag, pix, exp);
      end
   endtask

   task automatic cyc(input logic cs, input logic pe, input logic [31:0] d);
      char_stb = cs; pix_en = pe; plane_data = d;
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      cyc(0, 0, 32'd0);
      cyc(0, 0, 32'd0);
      check(4'd0, "R1");
      rst_n = 1'b1;
   endtask

   // one snapshot spanning `ratio` character clocks, with random idle gaps
   task automatic frame(input int m, input int ratio, input logic [31:0] d, input string tag);
      logic [3:0] held;
      for (int k = 0; k < 8 * ratio; k++) begin
         if (k != 0 && ($urandom % 5) == 0) begin
            held = pix;
            cyc(0, 0, $urandom);
            check(held, "R7");
         end
         cyc((k % 8) == 0, 1, (k == 0) ? d : $urandom);
         if (k == 0) check(exp_pix(d, m, k), "R6");
         else if ((m != 3 && k >= 8) || k >= 16) check(exp_pix(d, m, k), "R9");
         else if (k % 8 == 0) check(exp_pix(d, m, k), "R8");
         else check(exp_pix(d, m, k), tag);
      end
   endtask

   initial begin
      #4_000_000;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'h5EED_0042));
      @(negedge clk);
      do_reset();

      // directed patterns, one load per strobe
      div_sel = 2'd0;
      mode = 2'd0; frame(0, 1, 32'h8001_FF0F, "R2");
      mode = 2'd1; frame(1, 1, 32'hC3A5_5A3C, "R3");
      mode = 2'd2; frame(2, 1, 32'h0123_4567, "R4");

      // random patterns in the eight-pixel formats
      for (int i = 0; i < 40; i++) begin
         mode = 2'(i % 3);
         frame(i % 3, 1, $urandom, (i % 3 == 0) ? "R2" : (i % 3 == 1) ? "R3" : "R4");
      end

      // chained single-bit format over two character clocks
      do_reset();
      div_sel = 2'd1; mode = 2'd3;
      frame(3, 2, 32'hF00F_8181, "R5");
      for (int i = 0; i < 10; i++) frame(3, 2, $urandom, "R5");

      // every fourth strobe: the shifter runs dry and skipped strobes are ignored
      do_reset();
      div_sel = 2'd2;
      for (int i = 0; i < 8; i++) begin
         mode = 2'(i % 4);
         frame(i % 4, 4, $urandom, "R8");
      end
      div_sel = 2'd3; mode = 2'd2;
      frame(2, 4, $urandom, "R8");

      // load without enable, then the next enable shows pixel 0
      do_reset();
      div_sel = 2'd0; mode = 2'd0;
      d = 32'h3C5A_96E1;
      cyc(1, 0, d);
      check(4'd0, "R7");
      cyc(0, 1, 32'd0);
      check(exp_pix(d, 0, 0), "R7");
      cyc(0, 1, 32'd0);
      check(exp_pix(d, 0, 1), "R7");

      // reset in mid stream clears output
      do_reset();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule